// File: doc/BRIEF.md
# Counting Sort Engine

The block sorts one batch of unsigned values at a time without any comparator or swap network. It keeps one occurrence counter for every possible input value. A batch runs in three phases. First every counter is cleared. Then the input words are taken one per cycle, and the counter addressed by each word is increased by one. Finally the counters are walked in ascending value order, and each value is emitted once for every occurrence that was counted.

A controller pulses a start, streams the batch in under a valid/ready pair, and collects the sorted words from a valid-qualified output stream. A single-cycle done flag marks the end of the batch. The runtime depends only on the batch size and on how the values are spread over the value range. It never depends on the order in which the values arrive.

Top module: `cnt_sort_engine`

## Requirements
- R1: While rst_ni is low and afterwards until a start is taken, in_ready_o, out_valid_o and done_o are low.
- R2: A high start_i at a rising edge while idle begins a clear phase lasting 2^DATA_W cycles. Counting the start edge as edge 1, in_ready_o is first high after edge 2^DATA_W + 1 (257 for the defaults).
- R3: Every counter is zeroed at the start of each batch, so a batch's output never contains values left over from an earlier batch.
- R4: A word is taken only at a rising edge where in_valid_i and in_ready_o are both high. in_ready_o stays high until exactly BATCH_N words have been taken. in_valid_i and in_data_i have no effect at any other time.
- R5: Every taken word adds exactly one to its value's counter, including a word equal to the word taken in the cycle just before it. No update is lost.
- R6: The output words, in stream order, are the batch sorted in ascending unsigned order, with each value repeated as often as it occurred.
- R7: Each batch produces exactly BATCH_N cycles with out_valid_o high, one word per cycle at most.
- R8: done_o is high for exactly one cycle. That cycle immediately follows the cycle of the last output word, and out_valid_o is low in it.
- R9: start_i has no effect unless the block is idle, including in the cycle where done_o is high. A start held high through a whole batch does not restart it.
- R10: The output walk spends one cycle per output word and one cycle per zero-count value below the largest input value (E cycles in total). When the words are fed back to back, done_o is first high after edge 2^DATA_W + BATCH_N + 3 + E, counting the start edge as edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new batch when idle |
| in_valid_i | input | 1 | Input word present |
| in_data_i | input | DATA_W | Unsigned input word |
| in_ready_o | output | 1 | High during the counting phase; a word is taken when valid and ready are both high |
| out_valid_o | output | 1 | Sorted word present on out_data_o |
| out_data_o | output | DATA_W | Sorted output word |
| done_o | output | 1 | One-cycle pulse after the last output word of a batch |

## Verification
The checker tracks batch boundaries only through done_o. It therefore assumes that a batch, once started, is never cut short by anything but reset, and that in_data_i carries defined values whenever in_valid_i is high. The bench never pulses reset in the middle of a batch and always drives known data. It also deliberately violates the "start only when idle" and "valid only when ready" conventions, holding start_i and in_valid_i high with junk data through the clear, flush and output phases, to show that both are ignored. Gapped input feeds exercise the pipelined increment without the back-to-back timing. Back-to-back feeds of repeated values stress the forwarding path.

// File: rtl/cnt_sort_pkg.sv
package cnt_sort_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_COUNT,
    PH_FLUSH,
    PH_PRIME,
    PH_EMIT,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/cnt_sort_mem.sv
// Count storage: one write port, one registered read port (read-before-write).
module cnt_sort_mem #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cnt_sort_accum.sv
// Increment stage: read issued at accept, write one cycle later, with bypass of
// the previous cycle's write to cover the read-before-write hazard.
module cnt_sort_accum #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic [CNT_W-1:0]  rdata_i,
  output logic              inc_we_o,
  output logic [ADDR_W-1:0] inc_addr_o,
  output logic [CNT_W-1:0]  inc_val_o
);
  logic              p_vld_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic              fwd_vld_q;
  logic [ADDR_W-1:0] fwd_addr_q;
  logic [CNT_W-1:0]  fwd_val_q;
  logic [CNT_W-1:0]  base;
  logic              hit;

  assign hit        = fwd_vld_q && (fwd_addr_q == p_addr_q);
  assign base       = hit ? fwd_val_q : rdata_i;
  assign inc_we_o   = p_vld_q;
  assign inc_addr_o = p_addr_q;
  assign inc_val_o  = base + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld_q    <= 1'b0;
      p_addr_q   <= '0;
      fwd_vld_q  <= 1'b0;
      fwd_addr_q <= '0;
      fwd_val_q  <= '0;
    end else begin
      p_vld_q   <= take_i;
      fwd_vld_q <= p_vld_q;
      if (take_i) p_addr_q <= data_i;
      if (p_vld_q) begin
        fwd_addr_q <= p_addr_q;
        fwd_val_q  <= inc_val_o;
      end
    end
  end
endmodule

// File: rtl/cnt_sort_ctrl.sv
// Phase sequencer, clear sweep, input tally and ascending emit walk.
module cnt_sort_ctrl
  import cnt_sort_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 6,
  parameter int BATCH_N = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [CNT_W-1:0]  rdata_i,
  output logic              in_ready_o,
  output logic              take_o,
  output logic              clr_we_o,
  output logic [ADDR_W-1:0] clr_addr_o,
  output logic [ADDR_W-1:0] scan_addr_o,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_data_o,
  output logic              done_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  LAST_WORD = CNT_W'(BATCH_N - 1);

  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] clr_idx_q, clr_idx_d;
  logic [CNT_W-1:0]  acc_q, acc_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0]  taken_q, taken_d;
  logic [CNT_W-1:0]  emit_n_q, emit_n_d;
  logic              emit;

  assign in_ready_o  = (phase_q == PH_COUNT);
  assign take_o      = in_ready_o && in_valid_i;
  assign clr_we_o    = (phase_q == PH_CLEAR);
  assign clr_addr_o  = clr_idx_q;
  // rdata_i holds the count of idx_q during the walk
  assign emit        = (phase_q == PH_EMIT) && (rdata_i != '0);
  assign out_valid_o = emit;
  assign out_data_o  = idx_q;
  assign done_o      = (phase_q == PH_DONE);
  // read the index that will be current next cycle
  assign scan_addr_o = idx_d;

  always_comb begin
    phase_d   = phase_q;
    clr_idx_d = clr_idx_q;
    acc_d     = acc_q;
    idx_d     = idx_q;
    taken_d   = taken_q;
    emit_n_d  = emit_n_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d   = PH_CLEAR;
          clr_idx_d = '0;
          acc_d     = '0;
          idx_d     = '0;
          taken_d   = '0;
          emit_n_d  = '0;
        end
      end
      PH_CLEAR: begin
        clr_idx_d = clr_idx_q + ADDR_W'(1);
        if (clr_idx_q == LAST_ADDR) phase_d = PH_COUNT;
      end
      PH_COUNT: begin
        if (in_valid_i) begin
          acc_d = acc_q + CNT_W'(1);
          if (acc_q == LAST_WORD) phase_d = PH_FLUSH;
        end
      end
      PH_FLUSH: phase_d = PH_PRIME;
      PH_PRIME: phase_d = PH_EMIT;
      PH_EMIT: begin
        if (emit) begin
          emit_n_d = emit_n_q + CNT_W'(1);
          if (taken_q + CNT_W'(1) == rdata_i) begin
            idx_d   = idx_q + ADDR_W'(1);
            taken_d = '0;
          end else begin
            taken_d = taken_q + CNT_W'(1);
          end
          if (emit_n_q == LAST_WORD) phase_d = PH_DONE;
        end else begin
          idx_d = idx_q + ADDR_W'(1);
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      clr_idx_q <= '0;
      acc_q     <= '0;
      idx_q     <= '0;
      taken_q   <= '0;
      emit_n_q  <= '0;
    end else begin
      phase_q   <= phase_d;
      clr_idx_q <= clr_idx_d;
      acc_q     <= acc_d;
      idx_q     <= idx_d;
      taken_q   <= taken_d;
      emit_n_q  <= emit_n_d;
    end
  end
endmodule

// File: rtl/cnt_sort_engine.sv
module cnt_sort_engine #(
  parameter int DATA_W  = 8,
  parameter int BATCH_N = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(BATCH_N + 1);

  logic              take;
  logic              clr_we;
  logic [DATA_W-1:0] clr_addr;
  logic [DATA_W-1:0] scan_addr;
  logic              inc_we;
  logic [DATA_W-1:0] inc_addr;
  logic [CNT_W-1:0]  inc_val;
  logic              mem_we;
  logic [DATA_W-1:0] mem_waddr;
  logic [CNT_W-1:0]  mem_wdata;
  logic [DATA_W-1:0] mem_raddr;
  logic [CNT_W-1:0]  mem_rdata;

  // clear sweep and increments never overlap in time
  assign mem_we    = clr_we || inc_we;
  assign mem_waddr = clr_we ? clr_addr : inc_addr;
  assign mem_wdata = clr_we ? '0 : inc_val;
  assign mem_raddr = in_ready_o ? in_data_i : scan_addr;

  cnt_sort_ctrl #(
    .ADDR_W (DATA_W),
    .CNT_W  (CNT_W),
    .BATCH_N(BATCH_N)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .rdata_i    (mem_rdata),
    .in_ready_o (in_ready_o),
    .take_o     (take),
    .clr_we_o   (clr_we),
    .clr_addr_o (clr_addr),
    .scan_addr_o(scan_addr),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .done_o     (done_o)
  );

  cnt_sort_accum #(
    .ADDR_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .data_i    (in_data_i),
    .rdata_i   (mem_rdata),
    .inc_we_o  (inc_we),
    .inc_addr_o(inc_addr),
    .inc_val_o (inc_val)
  );

  cnt_sort_mem #(
    .ADDR_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/cnt_sort_chk.sv
module cnt_sort_chk #(
  parameter int DATA_W  = 8,
  parameter int BATCH_N = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              done_o
);
  localparam int CNT_W = $clog2(BATCH_N + 1);

  logic [CNT_W-1:0]  n_out_q;
  logic [CNT_W-1:0]  n_in_q;
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_out_q <= '0;
      n_in_q  <= '0;
      last_q  <= '0;
    end else begin
      if (done_o) n_out_q <= '0;
      else if (out_valid_o) n_out_q <= n_out_q + CNT_W'(1);
      if (done_o) n_in_q <= '0;
      else if (in_valid_i && in_ready_o) n_in_q <= n_in_q + CNT_W'(1);
      if (out_valid_o) last_q <= out_data_o;
    end
  end

  a_r6_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && n_out_q != '0) |-> out_data_o >= last_q);

  a_r7_out_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> n_out_q < CNT_W'(BATCH_N));

  a_r4_in_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> n_in_q < CNT_W'(BATCH_N));

  a_r4_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (!out_valid_o && !done_o));

  a_r8_done_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (n_out_q == CNT_W'(BATCH_N) && !out_valid_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_after_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_valid_o));
endmodule

bind cnt_sort_engine cnt_sort_chk #(
  .DATA_W (DATA_W),
  .BATCH_N(BATCH_N)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .done_o     (done_o)
);

// File: tb/tb_cnt_sort_engine.sv
module tb_cnt_sort_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int BATCH_N    = 48;
  localparam int DEPTH      = 1 << DATA_W;
  localparam int WD_LIMIT   = 150000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              in_valid_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              in_ready_o;
  logic              out_valid_o;
  logic [DATA_W-1:0] out_data_o;
  logic              done_o;

  cnt_sort_engine #(.DATA_W(DATA_W), .BATCH_N(BATCH_N)) dut (
    .clk_i, .rst_ni, .start_i, .in_valid_i, .in_data_i,
    .in_ready_o, .out_valid_o, .out_data_o, .done_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int got_n   = 0;
  int last_out_cyc = 0;
  int got [BATCH_N];
  int batch [BATCH_N];
  int exp_s [BATCH_N];

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  always @(negedge clk_i) begin
    if (out_valid_o) begin
      if (got_n < BATCH_N) got[got_n] = int'(out_data_o);
      got_n++;
      last_out_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int emit_cycles();
    int cnt [DEPTH];
    int mx = 0;
    int e  = BATCH_N;
    for (int v = 0; v < DEPTH; v++) cnt[v] = 0;
    for (int i = 0; i < BATCH_N; i++) begin
      cnt[batch[i]]++;
      if (batch[i] > mx) mx = batch[i];
    end
    for (int v = 0; v < mx; v++) if (cnt[v] == 0) e++;
    return e;
  endfunction

  task automatic build_expected();
    for (int i = 0; i < BATCH_N; i++) exp_s[i] = batch[i];
    for (int i = 1; i < BATCH_N; i++) begin
      int key = exp_s[i];
      int j = i - 1;
      while (j >= 0 && exp_s[j] > key) begin
        exp_s[j + 1] = exp_s[j];
        j--;
      end
      exp_s[j + 1] = key;
    end
  endtask

  task automatic run_batch(input string rtag, input bit gaps, input bit noise);
    int start_cyc, done_cyc, e, mism, first_bad;
    build_expected();
    e = emit_cycles();
    @(negedge clk_i);
    start_i = 1'b1;
    start_cyc = cyc;
    got_n = 0;
    if (noise) begin
      in_valid_i = 1'b1;
      in_data_i  = 8'h77;
    end
    @(negedge clk_i);
    if (!noise) start_i = 1'b0;
    while (!in_ready_o && cyc < start_cyc + 400) @(negedge clk_i);
    chk(cyc == start_cyc + DEPTH + 1, "R2", "ready edge", cyc - start_cyc, DEPTH + 1);
    for (int i = 0; i < BATCH_N; i++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        repeat (g) begin
          in_valid_i = 1'b0;
          @(negedge clk_i);
        end
      end
      in_valid_i = 1'b1;
      in_data_i  = DATA_W'(batch[i]);
      @(negedge clk_i);
    end
    if (noise) begin
      in_valid_i = 1'b1;
      in_data_i  = 8'h33;
    end else begin
      in_valid_i = 1'b0;
    end
    chk(!in_ready_o, "R4", "ready after last word", int'(in_ready_o), 0);
    while (!done_o && cyc < start_cyc + 2000) @(negedge clk_i);
    done_cyc = cyc;
    chk(done_o, "R8", "done seen", int'(done_o), 1);
    if (!gaps)
      chk(done_cyc == start_cyc + DEPTH + BATCH_N + 3 + e, "R10", "done edge",
          done_cyc - start_cyc, DEPTH + BATCH_N + 3 + e);
    chk(last_out_cyc == done_cyc - 1 && !out_valid_o, "R8", "done follows last word",
        done_cyc - last_out_cyc, 1);
    chk(got_n == BATCH_N, "R7", "output count", got_n, BATCH_N);
    mism = 0;
    first_bad = -1;
    for (int i = 0; i < BATCH_N; i++) begin
      if (got[i] != exp_s[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (first_bad < 0) first_bad = 0;
    chk(mism == 0, "R6", "sorted word", got[first_bad], exp_s[first_bad]);
    chk(mism == 0, rtag, "batch content", got[first_bad], exp_s[first_bad]);
    start_i    = 1'b0;
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk(!done_o, "R8", "done pulse width", int'(done_o), 0);
    repeat (3) @(negedge clk_i);
    chk(!in_ready_o && !out_valid_o && got_n == BATCH_N, "R9", "no restart",
        int'(in_ready_o) + got_n - BATCH_N, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(!in_ready_o && !out_valid_o && !done_o, "R1", "in reset",
        int'(in_ready_o) + int'(out_valid_o) + int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (300) @(negedge clk_i);
    chk(!in_ready_o && !out_valid_o && !done_o, "R1", "idle without start",
        int'(in_ready_o) + int'(out_valid_o) + int'(done_o), 0);

    // R5: same value every cycle, back to back
    for (int i = 0; i < BATCH_N; i++) batch[i] = 0;
    run_batch("R5", 1'b0, 1'b0);
    // all at the top value: longest walk
    for (int i = 0; i < BATCH_N; i++) batch[i] = DEPTH - 1;
    run_batch("R5", 1'b0, 1'b0);
    // R3: small values after a batch of top values
    for (int i = 0; i < BATCH_N; i++) batch[i] = $urandom_range(0, 15);
    run_batch("R3", 1'b0, 1'b0);
    // ascending spread
    for (int i = 0; i < BATCH_N; i++) batch[i] = i * 5;
    run_batch("R6", 1'b0, 1'b0);
    // descending, with junk input and a held start (R4, R9)
    for (int i = 0; i < BATCH_N; i++) batch[i] = DEPTH - 1 - i * 3;
    run_batch("R4", 1'b0, 1'b1);
    // repeated pairs, gapped feed
    for (int i = 0; i < BATCH_N; i++) batch[i] = ((i / 2) * 37) % DEPTH;
    run_batch("R5", 1'b1, 1'b0);
    // random batches
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < BATCH_N; i++) batch[i] = $urandom_range(0, DEPTH - 1);
      run_batch("R6", b[0], b[1]);
    end
    // narrow random range with many back-to-back duplicates
    for (int i = 0; i < BATCH_N; i++) batch[i] = 100 + $urandom_range(0, 2);
    run_batch("R5", 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule